// File: doc/BRIEF.md
# Rank Modulation Permutation Demodulator and Programming Sequencer

This block reads a group of cells whose stored value is carried only by the relative order of their quantized charge levels, not by any absolute threshold. On a capture strobe it sorts the present levels through a combinational network and registers the result in two forms. The first is a list of cell indices ordered from the highest level down. The second is a compact index from 0 to N!-1, computed with the factorial number system.

A separate programming sequencer writes a permutation. It latches a target order and leaves the lowest-ranked cell alone. It then works upward one rank at a time, issuing one raise pulse per cycle to the current cell until that cell sits above the cell just below it by a configurable margin. Cell levels only ever rise, so ordering the work this way means no cell has to be pushed past a level it might later need to stay under. The cell levels are expected to be read back live on the same level input while the sequencer runs.

Top module: `rankmod_demod`

## Requirements
- R1: After a capture, `permOut` lists every cell index exactly once. Slot s occupies bits [3s+2:3s], and slot 0 holds the cell with the highest level.
- R2: When two cells have equal levels, the cell with the lower index is placed in the earlier (higher-ranked) slot.
- R3: `permIdx` is the lexicographic rank of the slot list among all N! orderings, always below N!. For three cells: 0-1-2 gives 0, 0-2-1 gives 1, 1-0-2 gives 2, 1-2-0 gives 3, 2-0-1 gives 4, 2-1-0 gives 5.
- R4: `permOut` and `permIdx` take the sorted result of `levelsIn` at the clock edge where `sampleValid` is high. `permValid` is high for exactly the following cycle. Without `sampleValid` both outputs hold their value.
- R5: Reset leaves `permOut` as the identity list (slot s holds cell s), `permIdx` at 0, and `permValid`, `pulseEn`, `progBusy` and `progDone` at 0.
- R6: Programming raises cells in order from the second-lowest target rank up to the highest. The cell in the lowest target slot (slot N-1) never receives a pulse.
- R7: The sequencer pulses the current cell for as long as its level is not strictly greater than the level of the next-lower target cell plus `progMargin`. When that condition is met it moves to the next rank, and it issues at most one pulse per cycle.
- R8: `progBusy` is high while the sequencer is working. `progDone` is a single-cycle pulse once the highest cell has been placed. A `progStart` that arrives while the sequencer is busy is ignored.
- R9: Once programming has finished, capturing the cell levels returns exactly the target permutation.
- R10: All N! distinct level orders produce distinct `permIdx` values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| levelsIn | input | N_CELLS*LVL_W | Quantized cell levels, cell i at bits [i*LVL_W +: LVL_W] |
| sampleValid | input | 1 | Capture the present ordering |
| permOut | output | N_CELLS*3 | Cell indices, highest level first |
| permIdx | output | IDX_W | Lexicographic permutation index |
| permValid | output | 1 | Capture result updated in the previous edge |
| progStart | input | 1 | Start programming `progTarget` |
| progTarget | input | N_CELLS*3 | Target order, highest-ranked cell in slot 0 |
| progMargin | input | LVL_W | Required level gap between adjacent ranks |
| pulseEn | output | 1 | Apply one raise pulse to `pulseCell` this cycle |
| pulseCell | output | 3 | Cell to raise |
| progBusy | output | 1 | Sequencer working |
| progDone | output | 1 | Programming finished (one cycle) |

## Verification
The case that is hardest to reach from the ports is the exact margin boundary inside a programming run. Here a cell's level moves one step per pulse and must end strictly above the lower neighbour plus the margin. An off-by-one in the comparison changes only the pulse count. The bench therefore includes a small cell model that raises a level by one on every pulse. It starts runs from equal or known levels, so the expected pulse count, the order of the pulsed cells and the final levels are all exact numbers. In one run it also asserts a second start partway through to show that the latched target does not change.

// File: rtl/rankmod_pkg.sv
`timescale 1ns/1ps
package rankmod_pkg;
  localparam int MAX_CELLS = 6;
  localparam int CELL_W = $clog2(MAX_CELLS);

  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  typedef struct packed {
    logic              capture;
    logic [CELL_W-1:0] selCur;
    logic [CELL_W-1:0] selPrev;
  } rm_strobe_t;
endpackage

// File: rtl/rankmod_datapath.sv
`timescale 1ns/1ps
module rankmod_datapath import rankmod_pkg::*; #(
  parameter int N_CELLS = 3,
  parameter int LVL_W = 8,
  localparam int IDX_W = $clog2(fact(N_CELLS))
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CELLS*LVL_W-1:0]    levelsIn,
  input  rm_strobe_t                  strb,
  input  logic [LVL_W-1:0]            margin,
  output logic [N_CELLS*CELL_W-1:0]   permOut,
  output logic [IDX_W-1:0]            permIdx,
  output logic                        permValid,
  output logic                        stepMet
);
  logic [LVL_W-1:0]  lvl    [N_CELLS];
  logic [CELL_W-1:0] rank   [N_CELLS];
  logic [CELL_W-1:0] sorted [N_CELLS];
  logic [IDX_W-1:0]  idxNext;
  logic [N_CELLS*CELL_W-1:0] listNext;
  logic [N_CELLS*CELL_W-1:0] identity;
  logic [LVL_W-1:0]  curLvl, prevLvl;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_unpack
    assign lvl[g] = levelsIn[g*LVL_W +: LVL_W];
    assign identity[g*CELL_W +: CELL_W] = CELL_W'(g);
    assign listNext[g*CELL_W +: CELL_W] = sorted[g];
  end

  // rank of each cell: number of cells ahead of it (higher level, or equal with lower index)
  always_comb begin
    for (int i = 0; i < N_CELLS; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N_CELLS; j++) begin
        if (j != i) begin
          if ((lvl[j] > lvl[i]) || ((lvl[j] == lvl[i]) && (j < i))) cnt++;
        end
      end
      rank[i] = CELL_W'(cnt);
    end
  end

  always_comb begin
    for (int s = 0; s < N_CELLS; s++) begin
      sorted[s] = '0;
      for (int i = 0; i < N_CELLS; i++) begin
        if (rank[i] == CELL_W'(s)) sorted[s] = CELL_W'(i);
      end
    end
  end

  // factorial-base (Lehmer) encoding of the sorted list
  always_comb begin
    int acc;
    acc = 0;
    for (int k = 0; k < N_CELLS; k++) begin
      int d;
      d = 0;
      for (int j = k + 1; j < N_CELLS; j++) begin
        if (sorted[j] < sorted[k]) d++;
      end
      acc = acc + d * fact(N_CELLS - 1 - k);
    end
    idxNext = IDX_W'(acc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permOut   <= identity;
      permIdx   <= '0;
      permValid <= 1'b0;
    end else begin
      permValid <= strb.capture;
      if (strb.capture) begin
        permOut <= listNext;
        permIdx <= idxNext;
      end
    end
  end

  // live comparison for the programming sequencer
  always_comb begin
    curLvl  = '0;
    prevLvl = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (strb.selCur == CELL_W'(i))  curLvl  = lvl[i];
      if (strb.selPrev == CELL_W'(i)) prevLvl = lvl[i];
    end
  end
  assign stepMet = {1'b0, curLvl} > ({1'b0, prevLvl} + {1'b0, margin});

  // R4: valid follows a capture by one cycle, outputs hold otherwise
  p_valid_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> permValid);
  p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> !permValid);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> ($stable(permOut) && $stable(permIdx)));
  // R3: index within range
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    permIdx < IDX_W'(fact(N_CELLS)));
  // R1: every cell appears exactly once in the list
  for (genvar c = 0; c < N_CELLS; c++) begin : g_uniq
    logic [N_CELLS-1:0] hit;
    for (genvar s = 0; s < N_CELLS; s++) begin : g_hit
      assign hit[s] = (permOut[s*CELL_W +: CELL_W] == CELL_W'(c));
    end
    p_cell_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) == 1);
  end
endmodule

// File: rtl/rankmod_ctrl.sv
`timescale 1ns/1ps
module rankmod_ctrl import rankmod_pkg::*; #(
  parameter int N_CELLS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sampleValid,
  input  logic                      progStart,
  input  logic [N_CELLS*CELL_W-1:0] progTarget,
  input  logic                      stepMet,
  output rm_strobe_t                strb,
  output logic                      pulseEn,
  output logic [CELL_W-1:0]         pulseCell,
  output logic                      progBusy,
  output logic                      progDone
);
  typedef enum logic [1:0] {S_IDLE, S_RAISE, S_DONE} seq_state_t;
  seq_state_t state;
  logic [N_CELLS*CELL_W-1:0] targetQ;
  logic [CELL_W-1:0] slotK;
  logic [CELL_W-1:0] curCell, prevCell;

  always_comb begin
    curCell  = '0;
    prevCell = '0;
    for (int s = 0; s < N_CELLS; s++) begin
      if (slotK == CELL_W'(s))                 curCell  = targetQ[s*CELL_W +: CELL_W];
      if ((slotK + CELL_W'(1)) == CELL_W'(s))  prevCell = targetQ[s*CELL_W +: CELL_W];
    end
  end

  assign strb.capture = sampleValid;
  assign strb.selCur  = curCell;
  assign strb.selPrev = prevCell;
  assign progBusy     = (state == S_RAISE);
  assign progDone     = (state == S_DONE);
  assign pulseEn      = progBusy && !stepMet;
  assign pulseCell    = curCell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      targetQ <= '0;
      slotK   <= '0;
    end else begin
      case (state)
        S_IDLE: if (progStart) begin
          targetQ <= progTarget;
          slotK   <= CELL_W'(N_CELLS - 2);
          state   <= S_RAISE;
        end
        S_RAISE: if (stepMet) begin
          if (slotK == '0) state <= S_DONE;
          else             slotK <= slotK - CELL_W'(1);
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: done lasts one cycle; target frozen while a run is active
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    progDone |=> !progDone);
  p_target_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(targetQ));
endmodule

// File: rtl/rankmod_demod.sv
`timescale 1ns/1ps
module rankmod_demod import rankmod_pkg::*; #(
  parameter int N_CELLS = 3,
  parameter int LVL_W = 8,
  localparam int IDX_W = $clog2(fact(N_CELLS))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CELLS*LVL_W-1:0]  levelsIn,
  input  logic                      sampleValid,
  output logic [N_CELLS*CELL_W-1:0] permOut,
  output logic [IDX_W-1:0]          permIdx,
  output logic                      permValid,
  input  logic                      progStart,
  input  logic [N_CELLS*CELL_W-1:0] progTarget,
  input  logic [LVL_W-1:0]          progMargin,
  output logic                      pulseEn,
  output logic [CELL_W-1:0]         pulseCell,
  output logic                      progBusy,
  output logic                      progDone
);
  rm_strobe_t strb;
  logic stepMet;

  rankmod_ctrl #(.N_CELLS(N_CELLS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .progStart(progStart), .progTarget(progTarget), .stepMet(stepMet),
    .strb(strb), .pulseEn(pulseEn), .pulseCell(pulseCell),
    .progBusy(progBusy), .progDone(progDone));

  rankmod_datapath #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .levelsIn(levelsIn), .strb(strb),
    .margin(progMargin), .permOut(permOut), .permIdx(permIdx),
    .permValid(permValid), .stepMet(stepMet));
endmodule

// File: tb/rankmod_demod_tb_top.sv
`timescale 1ns/1ps
module rankmod_demod_tb_top;
  localparam int N = 3;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic progStart = 1'b0;
  logic [N*3-1:0] progTarget = '0;
  logic [LW-1:0] progMargin = '0;
  logic [N*3-1:0] permOut;
  logic [2:0] permIdx;
  logic permValid, pulseEn, progBusy, progDone;
  logic [2:0] pulseCell;

  int lv [N];
  logic [N*LW-1:0] levelsIn;
  int nChecks = 0;
  int nFail = 0;
  int pulseLog [64];
  int pulseCnt = 0;
  bit modelOn = 0;

  always #10 clk = ~clk;

  assign levelsIn = {LW'(lv[2]), LW'(lv[1]), LW'(lv[0])};

  rankmod_demod #(.N_CELLS(N), .LVL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .levelsIn(levelsIn), .sampleValid(sampleValid),
    .permOut(permOut), .permIdx(permIdx), .permValid(permValid),
    .progStart(progStart), .progTarget(progTarget), .progMargin(progMargin),
    .pulseEn(pulseEn), .pulseCell(pulseCell), .progBusy(progBusy), .progDone(progDone));

  // cell model: each pulse raises the chosen cell by one level
  always @(negedge clk) begin
    if (modelOn && pulseEn) begin
      if (pulseCnt < 64) pulseLog[pulseCnt] = int'(pulseCell);
      pulseCnt = pulseCnt + 1;
      lv[pulseCell] = lv[pulseCell] + 1;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int slot(input int s);
    return int'(permOut[s*3 +: 3]);
  endfunction

  task automatic capture();
    @(negedge clk) sampleValid = 1'b1;
    @(negedge clk) sampleValid = 1'b0;
  endtask

  task automatic test_reset();
    check("R5", "slot0", slot(0), 0);
    check("R5", "slot1", slot(1), 1);
    check("R5", "slot2", slot(2), 2);
    check("R5", "idx", int'(permIdx), 0);
    check("R5", "valid/busy/done/pulse", int'({permValid, progBusy, progDone, pulseEn}), 0);
  endtask

  // every order of three distinct levels, enumerated lexicographically
  task automatic test_all_orders();
    int n = 0;
    int seen = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          if (a != b && b != c && a != c) begin
            lv[a] = 30; lv[b] = 20; lv[c] = 10;
            capture();
            check("R4", "valid after capture", int'(permValid), 1);
            check("R1", "slot0", slot(0), a);
            check("R1", "slot1", slot(1), b);
            check("R1", "slot2", slot(2), c);
            check("R3", "index", int'(permIdx), n);
            seen = seen | (1 << permIdx);
            n++;
          end
    check("R10", "distinct index mask", seen, 8'h3f);
  endtask

  task automatic test_ties();
    lv[0] = 7; lv[1] = 7; lv[2] = 7;
    capture();
    check("R2", "all equal slot0", slot(0), 0);
    check("R2", "all equal slot2", slot(2), 2);
    check("R2", "all equal idx", int'(permIdx), 0);
    lv[0] = 5; lv[1] = 9; lv[2] = 9;
    capture();
    check("R2", "pair tie slot0", slot(0), 1);
    check("R2", "pair tie slot1", slot(1), 2);
    check("R2", "pair tie idx", int'(permIdx), 3);
  endtask

  task automatic test_hold();
    lv[0] = 1; lv[1] = 50; lv[2] = 99;
    repeat (3) @(negedge clk);
    check("R4", "no valid without sample", int'(permValid), 0);
    check("R4", "list held", slot(0), 1);
    check("R4", "idx held", int'(permIdx), 3);
  endtask

  task automatic run_prog(input int t0, input int t1, input int t2, input int m,
                          input bit poke);
    int waited = 0;
    pulseCnt = 0;
    modelOn = 1;
    progMargin = LW'(m);
    progTarget = {3'(t2), 3'(t1), 3'(t0)};
    @(negedge clk) progStart = 1'b1;
    @(negedge clk) progStart = 1'b0;
    check("R8", "busy after start", int'(progBusy), 1);
    while (!progDone && waited < 200) begin
      if (poke && waited == 3) begin
        progTarget = {3'(t0), 3'(t1), 3'(t2)};
        progStart = 1'b1;
      end else progStart = 1'b0;
      @(negedge clk);
      waited++;
    end
    progStart = 1'b0;
    check("R8", "done seen", int'(progDone), 1);
    @(negedge clk);
    check("R8", "done one cycle", int'({progDone, progBusy}), 0);
    modelOn = 0;
  endtask

  task automatic test_prog_basic();
    lv[0] = 5; lv[1] = 3; lv[2] = 4;
    run_prog(2, 0, 1, 2, 0);
    check("R7", "pulse count", pulseCnt, 6);
    check("R6", "first pulse on second-lowest", pulseLog[0], 0);
    check("R6", "last pulse on highest", pulseLog[5], 2);
    check("R7", "cell0 level", lv[0], 6);
    check("R6", "lowest cell untouched", lv[1], 3);
    check("R7", "cell2 level", lv[2], 9);
    capture();
    check("R9", "readback slot0", slot(0), 2);
    check("R9", "readback slot2", slot(2), 1);
    check("R9", "readback idx", int'(permIdx), 4);
  endtask

  task automatic test_prog_already();
    lv[0] = 20; lv[1] = 10; lv[2] = 0;
    run_prog(0, 1, 2, 3, 0);
    check("R7", "no pulses when ordered", pulseCnt, 0);
  endtask

  task automatic test_prog_boundary();
    lv[0] = 0; lv[1] = 0; lv[2] = 0;
    run_prog(1, 2, 0, 4, 1);
    check("R7", "strict margin pulse count", pulseCnt, 15);
    check("R7", "cell2 exactly margin+1", lv[2], 5);
    check("R7", "cell1 exactly", lv[1], 10);
    check("R8", "restart ignored, cell0 idle", lv[0], 0);
    capture();
    check("R9", "readback idx", int'(permIdx), 3);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    lv[0] = 0; lv[1] = 0; lv[2] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_all_orders();
    test_ties();
    test_hold();
    test_prog_basic();
    test_prog_already();
    test_prog_boundary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule